// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers 32 interrupt request lines and latches a pending flag for each of them. Each line can be set up to act on its level or on its pulse. Every line also has a 2-bit priority and an enable bit. Software reaches all of these through a small word-wide register bus. On every cycle the controller names one winner with an ID and a valid flag. The winner is the pending, enabled interrupt with the smallest priority value. When two or more share that value, the lowest-numbered line wins.

A consumer takes the winning interrupt by raising the acknowledge input. This clears the winner's pending flag at the next clock edge. A level line that is still high, or a fresh pulse on a pulse line, marks the flag pending again. The block does no preemption or context handling. It only keeps the pending state and does the arbitration.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all of these are zero: every pending flag, every enable bit, every mode bit, every priority and the stored previous sample of each line. `sel_valid` is low.
- R2: The register map is as follows.
  - Word addresses 0 to 7 hold the priorities. Interrupt M is at address M/4, in lane M%4, in bits [8*(M%4)+7 : 8*(M%4)+6].
  - Address 8 is the enable register. Bit i enables interrupt i.
  - Address 9 is the mode register. Bit i set to 1 makes line i a pulse line, and 0 makes it a level line.
  - Any other address reads zero and ignores writes.
- R3: Bits [5:0] of every priority lane always read zero, and writes to them are ignored.
- R4: An access with `bus_be` other than 4'b1111 is a sub-word access. A sub-word write changes nothing, and a sub-word read returns zero.
- R5: A level line that is high at a rising clock edge sets its pending flag. While the line stays high, the flag is set again after an acknowledge.
- R6: A pulse line sets its pending flag at an edge where it is sampled high and its previous sample was low. A single-cycle pulse is enough. A line held high does not become pending again after an acknowledge.
- R7: Pending flags latch while their interrupt is disabled. Such a flag is not selected until its enable bit is set.
- R8: In the same cycle, `sel_id` names the enabled pending interrupt with the smallest priority value, with ties going to the lowest number. `sel_valid` is high exactly when such an interrupt exists.
- R9: `ack` with `sel_valid` high clears the selected flag at the next edge. A pulse rising in that same cycle keeps the flag set. `ack` with `sel_valid` low has no effect.
- R10: A pending flag stays set after its line falls, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ack | input | 1 | Acknowledge of the selected interrupt |
| sel_valid | output | 1 | A selectable interrupt exists |
| sel_id | output | 5 | Number of the selected interrupt |

## Verification
Some properties are checked on every cycle:
- the valid flag tracks exactly whether any enabled pending interrupt exists;
- the chosen ID is always enabled and pending;
- an acknowledge of a quiet line clears it;
- high level lines end up pending;
- sub-word reads and the unused lane bits always return zero.

Other behaviours can only be shown by the bench scenarios. These are the actual priority order with ties, the register address and lane mapping, a pulse line that is held high not re-pending, a pulse arriving in the same cycle as an acknowledge, and latching while disabled.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    REG_PRIO   = 2'd0,
    REG_ENABLE = 2'd1,
    REG_MODE   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input int addr, input int prio_regs);
    if (addr < prio_regs)           return REG_PRIO;
    else if (addr == prio_regs)     return REG_ENABLE;
    else if (addr == prio_regs + 1) return REG_MODE;
    else                            return REG_NONE;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [DATA_W/LANE_W-1:0]      bus_be,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output logic [NUM_IRQ-1:0]            enable,
  output logic [NUM_IRQ-1:0]            mode
);
  localparam int LANES     = DATA_W / LANE_W;
  localparam int PRIO_REGS = NUM_IRQ / LANES;
  localparam int ID_W      = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_IRQ-1:0]             enable_q, enable_d, mode_q, mode_d;
  logic                           full_word, wr_ok;
  reg_sel_e                       sel;

  assign full_word = (bus_be == '1);
  assign wr_ok     = bus_wr && full_word;
  assign sel       = decode_addr(int'(bus_addr), PRIO_REGS);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    localparam int REG_IDX = g / LANES;
    localparam int LANE    = g % LANES;
    logic we;
    assign we        = wr_ok && (sel == REG_PRIO) && (int'(bus_addr) == REG_IDX);
    assign prio_d[g] = we ? bus_wdata[LANE*LANE_W + LANE_W-1 -: PRIO_W] : prio_q[g];
  end

  assign enable_d = (wr_ok && sel == REG_ENABLE) ? bus_wdata[NUM_IRQ-1:0] : enable_q;
  assign mode_d   = (wr_ok && sel == REG_MODE)   ? bus_wdata[NUM_IRQ-1:0] : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q   <= '0;
      enable_q <= '0;
      mode_q   <= '0;
    end else begin
      prio_q   <= prio_d;
      enable_q <= enable_d;
      mode_q   <= mode_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (full_word) begin
      unique case (sel)
        REG_PRIO: begin
          for (int l = 0; l < LANES; l++) begin
            bus_rdata[l*LANE_W + LANE_W-1 -: PRIO_W] =
              prio_q[ID_W'(int'(bus_addr) * LANES + l)];
          end
        end
        REG_ENABLE: bus_rdata[NUM_IRQ-1:0] = enable_q;
        REG_MODE:   bus_rdata[NUM_IRQ-1:0] = mode_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign prio   = prio_q;
  assign enable = enable_q;
  assign mode   = mode_q;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] mode,
  input  logic [NUM_IRQ-1:0] clr,
  output logic [NUM_IRQ-1:0] pending
);
  logic [NUM_IRQ-1:0] pend_q, pend_d, prev_q, prev_d, set_lvl, set_pls;

  // level lines set on any high sample, pulse lines only on a rising sample
  assign set_lvl = irq_in & ~mode;
  assign set_pls = irq_in & ~prev_q & mode;
  assign pend_d  = set_lvl | set_pls | (pend_q & ~clr);
  assign prev_d  = irq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2
) (
  input  logic [NUM_IRQ-1:0]             req,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output logic                           valid,
  output logic [$clog2(NUM_IRQ)-1:0]     id
);
  localparam int ID_W = $clog2(NUM_IRQ);

  logic [PRIO_W-1:0] best;

  // ascending scan with a strict compare keeps the lowest number on ties
  always_comb begin
    valid = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (req[i] && (!valid || prio[i] < best)) begin
        valid = 1'b1;
        best  = prio[i];
        id    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W/8-1:0]        bus_be,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       ack,
  output logic                       sel_valid,
  output logic [$clog2(NUM_IRQ)-1:0] sel_id
);
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_w;
  logic [NUM_IRQ-1:0]             enable_w, mode_w, pending_w, clr_w;

  irq_cfg_regs #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prio(prio_w), .enable(enable_w), .mode(mode_w)
  );

  assign clr_w = (ack && sel_valid) ? (NUM_IRQ'(1) << sel_id) : '0;

  irq_pend_latch #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode(mode_w),
    .clr(clr_w), .pending(pending_w)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .req(pending_w & enable_w), .prio(prio_w), .valid(sel_valid), .id(sel_id)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_IRQ-1:0]         irq_in,
  input logic                       ack,
  input logic                       sel_valid,
  input logic [$clog2(NUM_IRQ)-1:0] sel_id,
  input logic [NUM_IRQ-1:0]         pending,
  input logic [NUM_IRQ-1:0]         enable,
  input logic [NUM_IRQ-1:0]         mode,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W/8-1:0]        bus_be,
  input logic [DATA_W-1:0]          bus_rdata
);
  localparam int LANES     = DATA_W / 8;
  localparam int PRIO_REGS = NUM_IRQ / LANES;

  function automatic logic [DATA_W-1:0] unused_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++) m[l*8 +: 6] = 6'h3F;
    return m;
  endfunction

  assert_valid_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid == (|(pending & enable)));

  assert_sel_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (pending[sel_id] && enable[sel_id]));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sel_valid && !irq_in[sel_id]) |=> !pending[$past(sel_id)]);

  assert_level_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & $past(irq_in & ~mode)) == $past(irq_in & ~mode)));

  assert_subword_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be != '1) |-> (bus_rdata == '0));

  assert_lane_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) < PRIO_REGS) |-> ((bus_rdata & unused_mask()) == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack),
  .sel_valid(sel_valid), .sel_id(sel_id),
  .pending(pending_w), .enable(enable_w), .mode(mode_w),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ack;
  logic        sel_valid;
  logic [4:0]  sel_id;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack(ack), .sel_valid(sel_valid), .sel_id(sel_id)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_sel(input string req, input logic v, input logic [4:0] id);
    chk(req, "sel_valid", 32'(sel_valid), 32'(v));
    if (v) chk(req, "sel_id", 32'(sel_id), 32'(id));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_be = be;
    #1;
    chk(req, "rdata", bus_rdata, exp);
    bus_be = 4'hF;
  endtask

  task automatic pulse_line(input int n);
    @(negedge clk); irq_in[n] = 1'b1;
    @(negedge clk); irq_in[n] = 1'b0;
    #1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk_sel("R1", 1'b0, 5'd0);
    for (int a = 0; a < 10; a++) rd_chk("R1", 4'(a), 4'hF, 32'h0);
  endtask

  task automatic t_regs();
    wr(4'd3, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3", 4'd3, 4'hF, 32'hC0C0_C0C0);
    wr(4'd3, 32'h1234_5678, 4'b0011);
    rd_chk("R4", 4'd3, 4'hF, 32'hC0C0_C0C0);
    rd_chk("R4", 4'd3, 4'b1110, 32'h0);
    wr(4'd8, 32'hA5A5_0F0F, 4'hF);
    rd_chk("R2", 4'd8, 4'hF, 32'hA5A5_0F0F);
    wr(4'd12, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R2", 4'd12, 4'hF, 32'h0);
    wr(4'd9, 32'h0000_0081, 4'hF);
    rd_chk("R2", 4'd9, 4'hF, 32'h0000_0081);
    wr(4'd9, 32'h0, 4'hF);
    wr(4'd8, 32'h0, 4'hF);
  endtask

  task automatic t_level();
    wr(4'd8, 32'h1 << 5, 4'hF);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); #1;
    chk_sel("R5", 1'b1, 5'd5);
    do_ack();
    chk_sel("R5", 1'b1, 5'd5);
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk); #1;
    chk_sel("R10", 1'b1, 5'd5);
    do_ack();
    chk_sel("R9", 1'b0, 5'd0);
    wr(4'd8, 32'h0, 4'hF);
  endtask

  task automatic t_pulse();
    wr(4'd9, 32'h1 << 7, 4'hF);
    wr(4'd8, 32'h1 << 7, 4'hF);
    pulse_line(7);
    chk_sel("R6", 1'b1, 5'd7);
    do_ack();
    chk_sel("R6", 1'b0, 5'd0);
    @(negedge clk); irq_in[7] = 1'b1;
    @(negedge clk); #1;
    chk_sel("R6", 1'b1, 5'd7);
    do_ack();
    repeat (2) @(negedge clk);
    #1;
    chk_sel("R6", 1'b0, 5'd0);
    @(negedge clk); irq_in[7] = 1'b0;
    pulse_line(7);
    @(negedge clk); ack = 1'b1; irq_in[7] = 1'b1;
    @(negedge clk); ack = 1'b0; irq_in[7] = 1'b0;
    #1;
    chk_sel("R9", 1'b1, 5'd7);
    do_ack();
    chk_sel("R9", 1'b0, 5'd0);
    wr(4'd9, 32'h0, 4'hF);
    wr(4'd8, 32'h0, 4'hF);
  endtask

  task automatic t_disabled();
    pulse_line(9);
    chk_sel("R7", 1'b0, 5'd0);
    do_ack();
    wr(4'd8, 32'h1 << 9, 4'hF);
    #1;
    chk_sel("R7", 1'b1, 5'd9);
    do_ack();
    chk_sel("R9", 1'b0, 5'd0);
    wr(4'd8, 32'h0, 4'hF);
  endtask

  task automatic t_priority();
    wr(4'd0, 32'h8000_0000, 4'hF);
    wr(4'd3, 32'h0000_4000, 4'hF);
    wr(4'd5, 32'h0000_0040, 4'hF);
    rd_chk("R2", 4'd3, 4'hF, 32'h0000_4000);
    pulse_line(3);
    pulse_line(13);
    pulse_line(20);
    wr(4'd8, (32'h1 << 3) | (32'h1 << 13) | (32'h1 << 20), 4'hF);
    #1;
    chk_sel("R8", 1'b1, 5'd13);
    do_ack();
    chk_sel("R8", 1'b1, 5'd20);
    do_ack();
    chk_sel("R8", 1'b1, 5'd3);
    do_ack();
    chk_sel("R8", 1'b0, 5'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr = 1'b0;
    bus_be = 4'hF; bus_wdata = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_level();
    t_pulse();
    t_disabled();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule